// File: doc/BRIEF.md
# Auto-Increment Byte Program Sequencer

This block runs the streaming byte-program mode of a serial flash. A command-decode front end hands it one event for each completed chip-select frame: an opcode, a 24-bit address and one data byte. The first streaming program command supplies both a start address and a byte. Each later streaming command supplies only a byte, and the sequencer writes that byte to the location after the previous one, using an address pointer that it keeps from one frame to the next. The front end reads `aai_o` to decide whether the next streaming frame carries an address.

Each accepted byte starts a self-timed write of `PROG_CYCLES` clock cycles. `busy_o` is high for the whole write. At the end of the write the byte is merged into the internal array with flash semantics, so a write can only clear bits. A write-enable latch must be set before streaming can start. Streaming stops when a write-disable command arrives. It also stops by itself after the highest unprotected byte has been written, because the pointer never wraps. The top `PROT_BYTES` locations of the array are write-protected. A read port lets the surrounding logic see the array contents.

Top module: `aai_prog_seq`

## Requirements
- R1: With the write-enable latch set, no write in progress and streaming mode off, a command with opcode 8'hAF and a start address no higher than MEM_BYTES-PROT_BYTES-1 turns streaming mode on and programs its data byte at that address.
- R2: While streaming mode is on, each accepted 8'hAF command ignores `cmd_addr_i` and programs its byte at the previous programmed address plus one.
- R3: An accepted byte sets `busy_o` for exactly PROG_CYCLES cycles, starting the cycle after the command. The array location keeps its old value until `busy_o` falls.
- R4: The write-disable opcode 8'h04 clears both streaming mode and the write-enable latch in the cycle after it arrives.
- R5: After the byte at address MEM_BYTES-PROT_BYTES-1 has been programmed, streaming mode and the write-enable latch both clear, and a following 8'hAF command has no effect.
- R6: An 8'hAF start command whose address is above MEM_BYTES-PROT_BYTES-1 is ignored. No write starts, streaming mode stays off, the array is unchanged and the write-enable latch keeps its value.
- R7: An 8'hAF command received while the write-enable latch is clear is ignored.
- R8: An 8'hAF command received while `busy_o` is high is ignored. Neither its byte nor its address is used, and the pointer does not advance.
- R9: The stored byte becomes the old byte AND the new byte.
- R10: After reset, `busy_o`, `wel_o` and `aai_o` are low and every array byte reads 8'hFF.
- R11: The write-enable opcode 8'h06 sets the write-enable latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle pulse: a decoded command event |
| cmd_op_i | input | 8 | Opcode of the event |
| cmd_addr_i | input | 24 | Address field, used only by the start command |
| cmd_data_i | input | 8 | Data byte of a program command |
| rd_addr_i | input | $clog2(MEM_BYTES) | Array read address |
| rd_data_o | output | 8 | Array byte at `rd_addr_i` (combinational) |
| busy_o | output | 1 | Self-timed byte write in progress |
| wel_o | output | 1 | Write-enable latch |
| aai_o | output | 1 | Streaming mode on: next program frame carries no address |

## Verification
The bench drives a continuation frame whose address field differs from the pointer. A design that trusted that field would write the byte to the wrong location. It ends the stream on the last unprotected byte and then sends one more program command. A wrapping or non-terminating pointer would write the bottom of the array or the protected region. It sends a program command during an active write, and checks that the pointer neither advances nor takes the byte. It also reprograms a byte that is already written, to catch a design that overwrites instead of ANDing. Finally, it measures the exact length of `busy_o` and checks that the array is unchanged before the write ends, which catches writes that land early or a timer that is off by one.

// File: rtl/aai_pkg.sv
package aai_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_AAI  = 8'hAF;
endpackage

// File: rtl/aai_timer.sv
module aai_timer #(
  parameter int PROG_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= LOAD;
      busy_q <= 1'b1;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);  // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);  // R3
endmodule

// File: rtl/aai_mem.sv
module aai_mem #(
  parameter int MEM_BYTES = 256,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [MEM_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[waddr_i] <= mem_q[waddr_i] & wdata_i;  // program clears bits only
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/aai_ctrl.sv
module aai_ctrl
  import aai_pkg::*;
#(
  parameter int MEM_BYTES  = 256,
  parameter int PROT_BYTES = 32,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_op_i,
  input  logic [23:0]   cmd_addr_i,
  input  logic [7:0]    cmd_data_i,
  input  logic          busy_i,
  input  logic          done_i,
  output logic          start_o,
  output logic [AW-1:0] ptr_o,
  output logic [7:0]    data_o,
  output logic          wel_o,
  output logic          aai_o
);
  localparam int          TOP    = MEM_BYTES - PROT_BYTES - 1;
  localparam logic [23:0] TOP_24 = 24'(TOP);
  localparam logic [AW-1:0] TOP_AW = AW'(TOP);

  logic [AW-1:0] ptr_q;
  logic [7:0]    data_q;
  logic          wel_q, aai_q;
  logic          is_af, acc_start, acc_cont;

  assign is_af     = cmd_valid_i && (cmd_op_i == OP_AAI);
  assign acc_start = is_af && wel_q && !busy_i && !aai_q && (cmd_addr_i <= TOP_24);
  assign acc_cont  = is_af && !busy_i && aai_q;
  assign start_o   = acc_start || acc_cont;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      data_q <= 8'hFF;
      wel_q  <= 1'b0;
      aai_q  <= 1'b0;
    end else begin
      if (acc_start) begin
        ptr_q  <= cmd_addr_i[AW-1:0];
        data_q <= cmd_data_i;
        aai_q  <= 1'b1;
      end else if (acc_cont) begin
        ptr_q  <= ptr_q + 1'b1;
        data_q <= cmd_data_i;
      end
      if (cmd_valid_i && cmd_op_i == OP_WREN) wel_q <= 1'b1;
      if (cmd_valid_i && cmd_op_i == OP_WRDI) begin
        wel_q <= 1'b0;
        aai_q <= 1'b0;
      end
      // no wrap: last unprotected byte ends the stream
      if (done_i && aai_q && ptr_q == TOP_AW) begin
        wel_q <= 1'b0;
        aai_q <= 1'b0;
      end
    end
  end

  assign ptr_o  = ptr_q;
  assign data_o = data_q;
  assign wel_o  = wel_q;
  assign aai_o  = aai_q;

  AST_AAI_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aai_q |-> wel_q);  // R7
  AST_WRDI_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_WRDI) |=> (!aai_q && !wel_q));  // R4
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && aai_q && ptr_q == TOP_AW) |=> (!aai_q && !wel_q));  // R5
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_cont |=> (ptr_q == $past(ptr_q) + 1'b1));  // R2
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_af && busy_i) |=> ($stable(ptr_q) && $stable(data_q)));  // R8
  AST_PROT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_af && !aai_q && cmd_addr_i > TOP_24) |=> !aai_q);  // R6
endmodule

// File: rtl/aai_prog_seq.sv
module aai_prog_seq #(
  parameter int MEM_BYTES   = 256,
  parameter int PROT_BYTES  = 32,
  parameter int PROG_CYCLES = 4,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_op_i,
  input  logic [23:0]   cmd_addr_i,
  input  logic [7:0]    cmd_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          busy_o,
  output logic          wel_o,
  output logic          aai_o
);
  logic          start, busy, done;
  logic [AW-1:0] ptr;
  logic [7:0]    data;

  aai_ctrl #(.MEM_BYTES(MEM_BYTES), .PROT_BYTES(PROT_BYTES)) i_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_addr_i, .cmd_data_i,
    .busy_i(busy), .done_i(done), .start_o(start), .ptr_o(ptr),
    .data_o(data), .wel_o, .aai_o
  );

  aai_timer #(.PROG_CYCLES(PROG_CYCLES)) i_timer (
    .clk_i, .rst_ni, .start_i(start), .busy_o(busy), .done_o(done)
  );

  aai_mem #(.MEM_BYTES(MEM_BYTES)) i_mem (
    .clk_i, .rst_ni, .we_i(done), .waddr_i(ptr), .wdata_i(data),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  assign busy_o = busy;

  AST_WRITE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> busy);  // R3
endmodule

// File: tb/test_aai_prog_seq.sv
module test_aai_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int P = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_op = '0, cmd_data = '0;
  logic [23:0] cmd_addr = '0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy, wel, aai;
  int checks = 0, errors = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aai_prog_seq #(.MEM_BYTES(256), .PROT_BYTES(32), .PROG_CYCLES(P)) i_aai_prog_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .busy_o(busy), .wel_o(wel), .aai_o(aai)
  );

  // {op, addr, data, check addr, expected byte, aai, wel}
  localparam int NV = 17;
  localparam logic [57:0] VEC [NV] = '{
    {8'h06, 24'h000000, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b1},  // R11
    {8'hAF, 24'h000010, 8'hA5, 8'h10, 8'hA5, 1'b1, 1'b1},  // R1
    {8'hAF, 24'h000080, 8'h3C, 8'h11, 8'h3C, 1'b1, 1'b1},  // R2
    {8'hAF, 24'h000000, 8'hF0, 8'h12, 8'hF0, 1'b1, 1'b1},  // R2
    {8'h04, 24'h000000, 8'h00, 8'h12, 8'hF0, 1'b0, 1'b0},  // R4
    {8'hAF, 24'h000020, 8'h11, 8'h20, 8'hFF, 1'b0, 1'b0},  // R7
    {8'h06, 24'h000000, 8'h00, 8'h20, 8'hFF, 1'b0, 1'b1},
    {8'hAF, 24'h000020, 8'h0F, 8'h20, 8'h0F, 1'b1, 1'b1},
    {8'h04, 24'h000000, 8'h00, 8'h20, 8'h0F, 1'b0, 1'b0},
    {8'h06, 24'h000000, 8'h00, 8'h20, 8'h0F, 1'b0, 1'b1},
    {8'hAF, 24'h000020, 8'hF3, 8'h20, 8'h03, 1'b1, 1'b1},  // R9
    {8'h04, 24'h000000, 8'h00, 8'h20, 8'h03, 1'b0, 1'b0},
    {8'h06, 24'h000000, 8'h00, 8'hE0, 8'hFF, 1'b0, 1'b1},
    {8'hAF, 24'h0000E0, 8'h00, 8'hE0, 8'hFF, 1'b0, 1'b1},  // R6
    {8'hAF, 24'h0000DE, 8'h77, 8'hDE, 8'h77, 1'b1, 1'b1},
    {8'hAF, 24'h000000, 8'h66, 8'hDF, 8'h66, 1'b0, 1'b0},  // R5
    {8'hAF, 24'h000000, 8'h55, 8'hE0, 8'hFF, 1'b0, 1'b0}   // R5
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] op, input logic [23:0] a, input logic [7:0] d);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", {7'b0, busy}, 8'h00);
    chk("R10 wel", {7'b0, wel}, 8'h00);
    chk("R10 aai", {7'b0, aai}, 8'h00);
    rd_addr = 8'h00;
    chk("R10 mem[00]", rd_data, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'hDF, v);
    chk("R10 mem[DF]", v, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][57:50], VEC[i][49:26], VEC[i][25:18]);
      wait_idle();
      rd(VEC[i][17:10], v);
      chk($sformatf("vec%0d byte", i), v, VEC[i][9:2]);
      chk($sformatf("vec%0d aai", i), {7'b0, aai}, {7'b0, VEC[i][1]});
      chk($sformatf("vec%0d wel", i), {7'b0, wel}, {7'b0, VEC[i][0]});
    end

    // R2 ignored address field left location untouched
    rd(8'h80, v);
    chk("R2 mem[80] untouched", v, 8'hFF);
    // R5 no wrap into low memory
    rd(8'h00, v);
    chk("R5 mem[00] untouched", v, 8'hFF);

    // R3 busy length and late update
    send(8'h06, 24'h0, 8'h00);
    send(8'hAF, 24'h000030, 8'h12);
    rd(8'h30, v);
    chk("R3 busy on next cycle", {7'b0, busy}, 8'h01);
    chk("R3 old value during busy", v, 8'hFF);
    // R8 command during busy is ignored
    send(8'hAF, 24'h0, 8'h99);
    n = 2;
    while (busy) begin @(negedge clk); if (busy) n++; end
    chk("R3 busy length", 8'(n), 8'(P));
    rd(8'h30, v);
    chk("R3 byte after busy", v, 8'h12);
    rd(8'h31, v);
    chk("R8 byte not taken", v, 8'hFF);
    send(8'hAF, 24'h0, 8'h44);
    wait_idle();
    rd(8'h31, v);
    chk("R8 pointer not advanced", v, 8'h44);
    send(8'h04, 24'h0, 8'h00);
    chk("R4 aai cleared", {7'b0, aai}, 8'h00);

    finish_run();
  end
endmodule